// File: doc/BRIEF.md
# Byte-Commanded LED Switch Controller

This block connects two physical switches and two LEDs to a byte-wide command stream. Each LED is driven by the exclusive-OR of its synchronized switch and one software-owned register bit. Flipping the switch toggles the light, and so does flipping the register bit. The remote side can never override a switch.

The byte source shows a received byte and a flag that says the byte is valid. Every valid byte is taken in the same cycle through a take strobe. The byte's lowest bit selects the operation. A 1 makes it a write, which loads the two register bits from bits 1 and 2. A 0 makes it a read, which raises a send strobe toward the byte sink while a packed status byte sits on the outgoing data bus.

Top module: `cmd_led_ctrl`

## Requirements
- R1: Each LED output equals its synchronized switch XOR its register bit. LED 1 uses switch 1 and register bit 0. LED 2 uses switch 2 and register bit 1.
- R2: A byte with bit 0 = 1, taken while the valid flag is high, loads register bit 0 from command bit 1 and register bit 1 from command bit 2 at that clock edge. Bits 7 to 3 have no effect. For example, 0x01 clears both, 0x03 sets LED 1 only, 0x05 sets LED 2 only, and 0x07 sets both.
- R3: The register keeps its value on every edge where the valid flag is low or command bit 0 is 0.
- R4: While the valid flag is high and command bit 0 is 0, the send strobe is high in that same cycle. The register is unchanged.
- R5: The outgoing status byte is laid out as: bit 0 = switch 1, bit 1 = switch 2, bit 2 = LED 1, bit 3 = LED 2, bits 7 to 4 = 0. The LED bits equal the LED pins.
- R6: The take strobe is high in exactly the cycles where the valid flag is high, for reads and writes alike.
- R7: An active-low asynchronous reset clears both register bits, so afterwards each LED follows its switch.
- R8: A switch change reaches the LED pin and the status byte after exactly two rising clock edges.
- R9: The send strobe is never high for a write command, and never high while the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_i | input | 2 | Physical switch levels, asynchronous |
| led_o | output | 2 | LED drive |
| rx_data_i | input | 8 | Received command byte |
| rx_valid_i | input | 1 | Received byte is valid |
| rx_take_o | output | 1 | Consume the received byte |
| tx_data_o | output | 8 | Status reply byte |
| tx_send_o | output | 1 | Send the status byte |

## Verification
The assertions check on every cycle that:
- a write loads the register value, recovered as the LED pins XOR the switch bits of the status byte;
- the register holds when no write occurs;
- the send strobe only accompanies valid read commands;
- the upper status bits stay zero and the LED bits mirror the pins.

The bench's scenarios show the rest:
- the two-edge switch latency;
- the reset state with switches already set;
- a sweep of all 256 command bytes;
- every combination of switch and register state, checked against values computed from the requirements.

// File: rtl/cmd_led_pkg.sv
package cmd_led_pkg;
  parameter int NUM_CH    = 2;
  parameter int BYTE_W    = 8;
  parameter int SYNC_LEN  = 2;
  localparam int OP_BIT   = 0;
  localparam int FLD_LSB  = 1;
  localparam int FLD_MSB  = FLD_LSB + NUM_CH - 1;
  localparam int STAT_USE = 2 * NUM_CH;
endpackage

// File: rtl/sw_sync.sv
module sw_sync
  import cmd_led_pkg::*;
#(
  parameter int WIDTH = NUM_CH,
  parameter int DEPTH = SYNC_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = async_i;
    for (int k = 1; k < DEPTH; k++) stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= stage_d[k];
    end
  end

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_led_pkg::*;
(
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output logic              take_o,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [NUM_CH-1:0] wr_val_o
);
  localparam int IGN_W = BYTE_W - FLD_MSB - 1;
  logic [IGN_W-1:0] ign_bits_unused;

  always_comb begin
    take_o          = valid_i;
    wr_en_o         = valid_i &  cmd_i[OP_BIT];
    rd_en_o         = valid_i & ~cmd_i[OP_BIT];
    wr_val_o        = cmd_i[FLD_MSB:FLD_LSB];
    ign_bits_unused = cmd_i[BYTE_W-1:FLD_MSB+1];
  end
endmodule

// File: rtl/led_reg.sv
module led_reg
  import cmd_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic [NUM_CH-1:0] load_val_i,
  input  logic [NUM_CH-1:0] sw_sync_i,
  output logic [NUM_CH-1:0] led_o
);
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load_en_i) mask_d = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mix
    assign led_o[ch] = sw_sync_i[ch] ^ mask_q[ch];
  end
endmodule

// File: rtl/status_pack.sv
module status_pack
  import cmd_led_pkg::*;
(
  input  logic [NUM_CH-1:0] sw_i,
  input  logic [NUM_CH-1:0] led_i,
  output logic [BYTE_W-1:0] stat_o
);
  always_comb begin
    stat_o = '0;
    stat_o[NUM_CH-1:0]        = sw_i;
    stat_o[STAT_USE-1:NUM_CH] = led_i;
  end
endmodule

// File: rtl/cmd_led_ctrl.sv
module cmd_led_ctrl
  import cmd_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sw_i,
  output logic [NUM_CH-1:0] led_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_take_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_send_o
);
  logic [NUM_CH-1:0] sw_sync;
  logic              wr_en;
  logic [NUM_CH-1:0] wr_val;

  sw_sync #(.WIDTH(NUM_CH), .DEPTH(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(sw_i),
    .sync_o (sw_sync)
  );

  cmd_decode u_dec (
    .valid_i (rx_valid_i),
    .cmd_i   (rx_data_i),
    .take_o  (rx_take_o),
    .wr_en_o (wr_en),
    .rd_en_o (tx_send_o),
    .wr_val_o(wr_val)
  );

  led_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en_i (wr_en),
    .load_val_i(wr_val),
    .sw_sync_i (sw_sync),
    .led_o     (led_o)
  );

  status_pack u_stat (
    .sw_i  (sw_sync),
    .led_i (led_o),
    .stat_o(tx_data_o)
  );
endmodule

// File: rtl/cmd_led_ctrl_chk.sv
module cmd_led_ctrl_chk
  import cmd_led_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] led_o,
  input logic [BYTE_W-1:0] rx_data_i,
  input logic              rx_valid_i,
  input logic              rx_take_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_send_o
);
  logic [NUM_CH-1:0] mask_seen;
  assign mask_seen = led_o ^ tx_data_o[NUM_CH-1:0];

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_data_i[OP_BIT]) |=> mask_seen == $past(rx_data_i[FLD_MSB:FLD_LSB])); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_i && rx_data_i[OP_BIT]) |=> $stable(mask_seen)); // R3
  AST_SEND_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send_o |-> (rx_valid_i && !rx_data_i[OP_BIT])); // R9
  AST_READ_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !rx_data_i[OP_BIT]) |-> tx_send_o); // R4
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take_o |-> rx_valid_i); // R6
  AST_SEND_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send_o |-> rx_take_o); // R6
  AST_STAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_o[BYTE_W-1:STAT_USE] == '0); // R5
  AST_STAT_LED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_o[STAT_USE-1:NUM_CH] == led_o); // R5
endmodule

bind cmd_led_ctrl cmd_led_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .led_o     (led_o),
  .rx_data_i (rx_data_i),
  .rx_valid_i(rx_valid_i),
  .rx_take_o (rx_take_o),
  .tx_data_o (tx_data_o),
  .tx_send_o (tx_send_o)
);

// File: tb/cmd_led_ctrl_bench.sv
module cmd_led_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sw;
  logic [1:0] led;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_take;
  logic [7:0] tx_data;
  logic       tx_send;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] exp_mask;

  always #4 clk = ~clk;

  cmd_led_ctrl u_cmd_led_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_i(sw), .led_o(led),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_take_o(rx_take),
    .tx_data_o(tx_data), .tx_send_o(tx_send)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_of(input logic [1:0] s, input logic [1:0] m);
    return {4'b0, s ^ m, s};
  endfunction

  // one cycle with a valid byte; comb outputs checked mid-cycle
  task automatic issue(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    #1;
    chk("R6 take", rx_take, 1);
    chk("R4/R9 send", tx_send, {31'b0, ~b[0]});
    if (!b[0]) chk("R5 reply", tx_data, stat_of(sw, exp_mask));
    @(negedge clk);
    rx_valid = 1'b0;
    if (b[0]) exp_mask = b[2:1];
    #1;
    chk("R2/R3 led", led, sw ^ exp_mask);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw = 2'b00; rx_data = 8'h00; rx_valid = 1'b0; exp_mask = 2'b00;
    #21;
    chk("R7 reset led", led, 0);
    chk("R7 reset stat", tx_data, 0);
    chk("R9 idle send", tx_send, 0);
    chk("R6 idle take", rx_take, 0);
    @(negedge clk); rst_n = 1'b1;

    // R8 latency: change switch, observe after 1 and 2 edges
    @(negedge clk); sw = 2'b10;
    @(negedge clk); #1;
    chk("R8 one edge", led, 2'b00);
    @(negedge clk); #1;
    chk("R8 two edges", led, 2'b10);
    chk("R8 stat", tx_data, 8'h0A);

    // R1/R5 sweep of all switch and mask pairs
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        @(negedge clk); sw = s[1:0];
        @(negedge clk); @(negedge clk);
        issue({5'b10101, m[1:0], 1'b1});
        chk("R1 xor", led, s[1:0] ^ m[1:0]);
        issue(8'h00);
        #1 chk("R5 stat", tx_data, stat_of(s[1:0], m[1:0]));
      end
    end

    // all 256 command bytes, bits 7..3 ignored (R2), reads keep mask (R4)
    for (int b = 0; b < 256; b++) begin
      issue(b[7:0]);
      chk("R2 R4 mask", led ^ sw, exp_mask);
    end

    // R3: write byte present while valid low
    issue(8'h07);
    @(negedge clk); rx_data = 8'h01; rx_valid = 1'b0;
    #1 chk("R9 novalid send", tx_send, 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R3 no load", led, sw ^ 2'b11);

    // R7 reset again with switches set
    sw = 2'b01;
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 cleared", led, 0);
    @(negedge clk); rst_n = 1'b1; exp_mask = 2'b00;
    @(negedge clk); @(negedge clk); #1;
    chk("R7 follows sw", led, 2'b01);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule